// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the processor's 8-bit status word and updates it. When an arithmetic instruction finishes, the block works out carry, half-carry, zero and overflow from the two operands and the result. Logic instructions change only the zero flag. Rotate-through-carry instructions change only the carry flag. Subtraction uses the no-borrow convention: carry set means the subtraction did not borrow.

Two power-state flags sit in the same word. Both are driven by a small four-state machine that reacts to single-cycle event strobes:

- `PWR_RUN`: both flags clear.
- `PWR_HALT`: halted flag set.
- `PWR_WDT`: timeout flag set.
- `PWR_WDT_HALT`: both flags set.

The strobes are halt, watchdog-clear and watchdog-timeout. Every strobe combination leads to exactly one next state:

- **Timeout** moves the machine to a state with the timeout flag set. The halted flag is set if halt also fired, cleared if only the clear fired, and otherwise kept.
- **Halt without timeout** goes to `PWR_HALT`.
- **Clear without halt or timeout** goes to `PWR_RUN`.
- **No strobe** keeps the current state.

Software can overwrite the four arithmetic flags. The power-state flags cannot be written by software.

Top module: `sts_flag_reg`

## Requirements
- R1: With `op_class`=1 (add), C takes the carry out of opa+opb, and AC takes the carry out of the low 4-bit sum.
- R2: With `op_class`=2 (subtract opa-opb), C is 1 when opa>=opb unsigned (no borrow), and AC is 1 when opa[3:0]>=opb[3:0].
- R3: For add, subtract and logic operations, Z is 1 exactly when `result` is zero.
- R4: For add and subtract, OV is 1 when the signed result overflows, i.e. the carry into bit 7 differs from the carry out of bit 7.
- R5: With `op_class`=3 (logic), C, AC and OV keep their values.
- R6: With `op_class`=4 (rotate through carry), C takes `rot_cout`, and AC, Z and OV keep their values.
- R7: The halted flag is set by `halt_evt`. It is cleared by `clrwdt_evt` when halt is not also asserted.
- R8: The timeout flag is set by `wdt_tmo_evt`, and a timeout beats a simultaneous clear or halt. Otherwise `clrwdt_evt` or `halt_evt` clears it.
- R9: With `op_class` 0 or 5..7 and `wr_en`=1, `wr_flags[3:0]` loads {OV,Z,AC,C}. The power flags are untouched by the write. A write in a cycle carrying an operation is ignored.
- R10: `rd_data` is laid out as bit0 C, bit1 AC, bit2 Z, bit3 OV, bit4 halted, bit5 timeout, with bits 7:6 always 0.
- R11: An asynchronous low on `rst_n` clears every flag at once.
- R12: With no operation, no write and no strobe, every flag holds its value.
- All updates take effect at the clock edge that samples the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| op_class | input | 3 | 0 none, 1 add, 2 sub, 3 logic, 4 rotate, 5..7 none |
| opa | input | 8 | First ALU operand |
| opb | input | 8 | Second ALU operand (subtrahend for sub) |
| result | input | 8 | ALU result for the operation |
| rot_cout | input | 1 | Bit shifted out by a rotate through carry |
| halt_evt | input | 1 | Halt instruction strobe |
| clrwdt_evt | input | 1 | Watchdog-clear instruction strobe |
| wdt_tmo_evt | input | 1 | Watchdog timeout strobe |
| wr_en | input | 1 | Software write strobe |
| wr_flags | input | 4 | Write value for {OV,Z,AC,C} |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_ac | output | 1 | Half-carry flag |
| flag_z | output | 1 | Zero flag |
| flag_ov | output | 1 | Overflow flag |
| flag_pdf | output | 1 | Halted (power-down) flag |
| flag_to | output | 1 | Watchdog timeout flag |
| rd_data | output | 8 | Status word read value |

## Verification
The hardest situations to reach are the collisions:
- a timeout strobe in the same cycle as halt or clear, entered from each of the four power states;
- a software write landing in a cycle that also carries an operation.

Directed sequences first walk every power state and then fire each strobe combination there. A long seeded random phase follows; it mixes sparse strobes with every operation class and with writes. Operand pairs are chosen to hit the boundaries: equal operands, nibble-boundary borrows, and signed overflow in both directions.

// File: rtl/sts_pkg.sv
package sts_pkg;
    localparam int STS_W = 8;

    // Bit positions within the status word (read layout is behaviour)
    localparam int BIT_C   = 0;
    localparam int BIT_AC  = 1;
    localparam int BIT_Z   = 2;
    localparam int BIT_OV  = 3;
    localparam int BIT_PDF = 4;
    localparam int BIT_TO  = 5;

    typedef enum logic [2:0] {
        OPC_NONE  = 3'd0,
        OPC_ADD   = 3'd1,
        OPC_SUB   = 3'd2,
        OPC_LOGIC = 3'd3,
        OPC_ROT   = 3'd4
    } opc_t;

    typedef struct packed {
        logic ov;
        logic z;
        logic ac;
        logic c;
    } arith_flags_t;

    typedef enum logic [1:0] {
        PWR_RUN      = 2'd0,
        PWR_HALT     = 2'd1,
        PWR_WDT      = 2'd2,
        PWR_WDT_HALT = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/sts_arith_eval.sv
module sts_arith_eval
    import sts_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        opc,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] result,
    input  logic              rot_cout,
    output arith_flags_t      nxt_val,
    output arith_flags_t      upd_mask
);
    localparam int NIB_W = DATA_W / 2;

    logic              is_sub;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   full_sum;
    logic [NIB_W:0]    nib_sum;
    logic              msb_cin;

    // Subtraction is a + ~b + 1, so carry out means "no borrow"
    assign is_sub   = (opc == OPC_SUB);
    assign b_eff    = is_sub ? ~opb : opb;
    assign full_sum = {1'b0, opa} + {1'b0, b_eff} + {{DATA_W{1'b0}}, is_sub};
    assign nib_sum  = {1'b0, opa[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                    + {{NIB_W{1'b0}}, is_sub};
    assign msb_cin  = opa[DATA_W-1] ^ b_eff[DATA_W-1] ^ full_sum[DATA_W-1];

    always_comb begin
        nxt_val  = '0;
        upd_mask = '0;
        case (opc)
            OPC_ADD, OPC_SUB: begin
                nxt_val.c  = full_sum[DATA_W];
                nxt_val.ac = nib_sum[NIB_W];
                nxt_val.z  = ~|result;
                nxt_val.ov = msb_cin ^ full_sum[DATA_W];
                upd_mask   = '{ov: 1'b1, z: 1'b1, ac: 1'b1, c: 1'b1};
            end
            OPC_LOGIC: begin
                nxt_val.z  = ~|result;
                upd_mask.z = 1'b1;
            end
            OPC_ROT: begin
                nxt_val.c  = rot_cout;
                upd_mask.c = 1'b1;
            end
            default: begin
                nxt_val  = '0;
                upd_mask = '0;
            end
        endcase
    end
endmodule

// File: rtl/sts_power_fsm.sv
module sts_power_fsm
    import sts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_evt,
    input  logic clrwdt_evt,
    input  logic wdt_tmo_evt,
    output logic pdf,
    output logic to
);
    pwr_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_RUN;
        else        state_q <= state_d;
    end

    // Transitions: timeout always lands in a TO state; halt beats clear for PDF
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN: begin
                if (wdt_tmo_evt)   state_d = halt_evt ? PWR_WDT_HALT : PWR_WDT;
                else if (halt_evt) state_d = PWR_HALT;
                else               state_d = PWR_RUN;
            end
            PWR_HALT: begin
                if (wdt_tmo_evt)     state_d = (halt_evt || !clrwdt_evt) ? PWR_WDT_HALT : PWR_WDT;
                else if (halt_evt)   state_d = PWR_HALT;
                else if (clrwdt_evt) state_d = PWR_RUN;
                else                 state_d = PWR_HALT;
            end
            PWR_WDT: begin
                if (wdt_tmo_evt)     state_d = halt_evt ? PWR_WDT_HALT : PWR_WDT;
                else if (halt_evt)   state_d = PWR_HALT;
                else if (clrwdt_evt) state_d = PWR_RUN;
                else                 state_d = PWR_WDT;
            end
            PWR_WDT_HALT: begin
                if (wdt_tmo_evt)     state_d = (halt_evt || !clrwdt_evt) ? PWR_WDT_HALT : PWR_WDT;
                else if (halt_evt)   state_d = PWR_HALT;
                else if (clrwdt_evt) state_d = PWR_RUN;
                else                 state_d = PWR_WDT_HALT;
            end
        endcase
    end

    // Output decode
    always_comb begin
        pdf = 1'b0;
        to  = 1'b0;
        unique case (state_q)
            PWR_RUN:      begin pdf = 1'b0; to = 1'b0; end
            PWR_HALT:     begin pdf = 1'b1; to = 1'b0; end
            PWR_WDT:      begin pdf = 1'b0; to = 1'b1; end
            PWR_WDT_HALT: begin pdf = 1'b1; to = 1'b1; end
        endcase
    end
endmodule

// File: rtl/sts_flag_reg.sv
module sts_flag_reg
    import sts_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_class,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] result,
    input  logic              rot_cout,
    input  logic              halt_evt,
    input  logic              clrwdt_evt,
    input  logic              wdt_tmo_evt,
    input  logic              wr_en,
    input  logic [3:0]        wr_flags,
    output logic              flag_c,
    output logic              flag_ac,
    output logic              flag_z,
    output logic              flag_ov,
    output logic              flag_pdf,
    output logic              flag_to,
    output logic [STS_W-1:0]  rd_data
);
    localparam int AF_W = $bits(arith_flags_t);

    arith_flags_t af_q, af_nxt, af_mask;
    logic         op_any;

    sts_arith_eval #(.DATA_W(DATA_W)) eval_i (
        .opc      (op_class),
        .opa      (opa),
        .opb      (opb),
        .result   (result),
        .rot_cout (rot_cout),
        .nxt_val  (af_nxt),
        .upd_mask (af_mask)
    );

    sts_power_fsm pwr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_evt    (halt_evt),
        .clrwdt_evt  (clrwdt_evt),
        .wdt_tmo_evt (wdt_tmo_evt),
        .pdf         (flag_pdf),
        .to          (flag_to)
    );

    assign op_any = |af_mask;

    // Per-bit flag storage: operation update beats software write
    for (genvar i = 0; i < AF_W; i++) begin : g_af
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          af_q[i] <= 1'b0;
            else if (af_mask[i]) af_q[i] <= af_nxt[i];
            else if (wr_en && !op_any) af_q[i] <= wr_flags[i];
        end
    end

    assign flag_c  = af_q.c;
    assign flag_ac = af_q.ac;
    assign flag_z  = af_q.z;
    assign flag_ov = af_q.ov;

    always_comb begin
        rd_data          = '0;
        rd_data[BIT_C]   = af_q.c;
        rd_data[BIT_AC]  = af_q.ac;
        rd_data[BIT_Z]   = af_q.z;
        rd_data[BIT_OV]  = af_q.ov;
        rd_data[BIT_PDF] = flag_pdf;
        rd_data[BIT_TO]  = flag_to;
    end
endmodule

// File: rtl/sts_flag_reg_chk.sv
module sts_flag_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] op_class,
    input logic       halt_evt,
    input logic       clrwdt_evt,
    input logic       wdt_tmo_evt,
    input logic       wr_en,
    input logic       flag_c,
    input logic       flag_ac,
    input logic       flag_z,
    input logic       flag_ov,
    input logic       flag_pdf,
    input logic       flag_to
);
    logic no_op;
    assign no_op = (op_class == 3'd0) || (op_class > 3'd4);

    // R8
    tmo_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tmo_evt |=> flag_to);

    // R8
    to_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clrwdt_evt || halt_evt) && !wdt_tmo_evt) |=> !flag_to);

    // R7
    halt_sets_pdf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_evt |=> flag_pdf);

    // R7
    clr_clears_pdf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clrwdt_evt && !halt_evt) |=> !flag_pdf);

    // R5
    logic_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 3'd3) |=> $stable({flag_c, flag_ac, flag_ov}));

    // R6
    rot_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 3'd4) |=> $stable({flag_ac, flag_z, flag_ov}));

    // R9
    wr_power_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !halt_evt && !clrwdt_evt && !wdt_tmo_evt) |=> $stable({flag_pdf, flag_to}));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (no_op && !wr_en && !halt_evt && !clrwdt_evt && !wdt_tmo_evt)
        |=> $stable({flag_c, flag_ac, flag_z, flag_ov, flag_pdf, flag_to}));
endmodule

bind sts_flag_reg sts_flag_reg_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_class    (op_class),
    .halt_evt    (halt_evt),
    .clrwdt_evt  (clrwdt_evt),
    .wdt_tmo_evt (wdt_tmo_evt),
    .wr_en       (wr_en),
    .flag_c      (flag_c),
    .flag_ac     (flag_ac),
    .flag_z      (flag_z),
    .flag_ov     (flag_ov),
    .flag_pdf    (flag_pdf),
    .flag_to     (flag_to)
);

// File: tb/sts_flag_reg_tb_top.sv
`timescale 1ns/1ps
module sts_flag_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_class = '0;
    logic [7:0] opa = '0, opb = '0, result = '0;
    logic       rot_cout = 1'b0;
    logic       halt_evt = 1'b0, clrwdt_evt = 1'b0, wdt_tmo_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_flags = '0;
    logic       flag_c, flag_ac, flag_z, flag_ov, flag_pdf, flag_to;
    logic [7:0] rd_data;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Reference state
    bit m_c, m_ac, m_z, m_ov, m_pdf, m_to;
    string pend_tag = "R11";

    always #4 clk = ~clk;

    sts_flag_reg dut_i (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .opa(opa), .opb(opb),
        .result(result), .rot_cout(rot_cout), .halt_evt(halt_evt),
        .clrwdt_evt(clrwdt_evt), .wdt_tmo_evt(wdt_tmo_evt), .wr_en(wr_en),
        .wr_flags(wr_flags), .flag_c(flag_c), .flag_ac(flag_ac), .flag_z(flag_z),
        .flag_ov(flag_ov), .flag_pdf(flag_pdf), .flag_to(flag_to), .rd_data(rd_data)
    );

    function automatic logic [7:0] exp_word();
        return {2'b00, m_to, m_pdf, m_ov, m_z, m_ac, m_c};
    endfunction

    task automatic compare(input string tag);
        logic [7:0] act;
        act = {2'b00, flag_to, flag_pdf, flag_ov, flag_z, flag_ac, flag_c};
        vectors++;
        if (rd_data !== exp_word() || act !== exp_word()) begin
            errors++;
            $display("FAIL %s: rd_data=%02h flags=%02h expected=%02h", tag, rd_data, act, exp_word());
        end
    endtask

    function automatic int sval(input logic [7:0] v);
        return (v > 8'd127) ? int'(v) - 256 : int'(v);
    endfunction

    // One cycle: check state from the last edge, then drive and predict
    task automatic step(input string tag, input logic [2:0] opc, input logic [7:0] a,
                        input logic [7:0] b, input bit h, input bit cl, input bit t,
                        input bit w, input logic [3:0] wf);
        int s;
        bit rc;
        logic [7:0] res;
        @(negedge clk);
        compare(pend_tag);
        pend_tag = tag;
        rc  = a[7];
        res = 8'h00;
        case (opc)
            3'd1: res = a + b;
            3'd2: res = a - b;
            3'd3: res = a ^ b;
            3'd4: res = {a[6:0], m_c};
            default: res = a | b;
        endcase
        op_class = opc; opa = a; opb = b; result = res; rot_cout = rc;
        halt_evt = h; clrwdt_evt = cl; wdt_tmo_evt = t; wr_en = w; wr_flags = wf;
        if (opc == 3'd1) begin                      // R1 R3 R4
            m_c  = (int'(a) + int'(b)) > 255;
            m_ac = (int'(a[3:0]) + int'(b[3:0])) > 15;
            s    = sval(a) + sval(b);
            m_ov = (s > 127) || (s < -128);
            m_z  = (res == 8'h00);
        end else if (opc == 3'd2) begin             // R2 R3 R4
            m_c  = a >= b;
            m_ac = a[3:0] >= b[3:0];
            s    = sval(a) - sval(b);
            m_ov = (s > 127) || (s < -128);
            m_z  = (a == b);
        end else if (opc == 3'd3) begin             // R5
            m_z  = (res == 8'h00);
        end else if (opc == 3'd4) begin             // R6
            m_c  = rc;
        end else if (w) begin                       // R9
            {m_ov, m_z, m_ac, m_c} = wf;
        end
        if (h)       m_pdf = 1'b1;                  // R7
        else if (cl) m_pdf = 1'b0;
        if (t)            m_to = 1'b1;              // R8
        else if (cl || h) m_to = 1'b0;
    endtask

    task automatic idle(input string tag);
        step(tag, 3'd0, 8'h00, 8'h00, 0, 0, 0, 0, 4'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd11));
        {m_c, m_ac, m_z, m_ov, m_pdf, m_to} = '0;
        repeat (2) @(negedge clk);
        compare("R11");                             // reset state, R10 layout
        rst_n = 1'b1;
        // R1 add carries
        step("R1", 3'd1, 8'hF0, 8'h20, 0, 0, 0, 0, 4'h0);
        step("R1", 3'd1, 8'h0F, 8'h01, 0, 0, 0, 0, 4'h0);
        step("R3", 3'd1, 8'hFF, 8'h01, 0, 0, 0, 0, 4'h0);
        // R4 overflow both directions
        step("R4", 3'd1, 8'h7F, 8'h01, 0, 0, 0, 0, 4'h0);
        step("R4", 3'd1, 8'h80, 8'hFF, 0, 0, 0, 0, 4'h0);
        step("R4", 3'd2, 8'h80, 8'h01, 0, 0, 0, 0, 4'h0);
        step("R4", 3'd2, 8'h7F, 8'hFF, 0, 0, 0, 0, 4'h0);
        // R2 borrow convention
        step("R2", 3'd2, 8'h55, 8'h55, 0, 0, 0, 0, 4'h0);
        step("R2", 3'd2, 8'h10, 8'h01, 0, 0, 0, 0, 4'h0);
        step("R2", 3'd2, 8'h01, 8'h02, 0, 0, 0, 0, 4'h0);
        // R5 logic keeps C/AC/OV
        step("R5", 3'd2, 8'h80, 8'h01, 0, 0, 0, 0, 4'h0);
        step("R5", 3'd3, 8'h3C, 8'h3C, 0, 0, 0, 0, 4'h0);
        step("R5", 3'd3, 8'h3C, 8'h00, 0, 0, 0, 0, 4'h0);
        // R6 rotate through carry
        step("R6", 3'd4, 8'h80, 8'h00, 0, 0, 0, 0, 4'h0);
        step("R6", 3'd4, 8'h01, 8'h00, 0, 0, 0, 0, 4'h0);
        // R9 write, and write ignored with an op
        step("R9", 3'd0, 8'h00, 8'h00, 0, 0, 0, 1, 4'hA);
        step("R9", 3'd5, 8'h00, 8'h00, 0, 0, 0, 1, 4'h5);
        step("R9", 3'd3, 8'h01, 8'h00, 0, 0, 0, 1, 4'hF);
        idle("R12");
        idle("R12");
        // R7 R8 power flags and collisions from every state
        step("R7", 3'd0, 8'h00, 8'h00, 1, 0, 0, 0, 4'h0);
        step("R9", 3'd0, 8'h00, 8'h00, 0, 0, 0, 1, 4'h0);
        step("R8", 3'd0, 8'h00, 8'h00, 0, 1, 1, 0, 4'h0);
        step("R8", 3'd0, 8'h00, 8'h00, 1, 0, 0, 0, 4'h0);
        step("R8", 3'd0, 8'h00, 8'h00, 0, 0, 1, 0, 4'h0);
        step("R8", 3'd0, 8'h00, 8'h00, 1, 1, 1, 0, 4'h0);
        step("R7", 3'd0, 8'h00, 8'h00, 0, 1, 0, 0, 4'h0);
        step("R8", 3'd0, 8'h00, 8'h00, 1, 0, 1, 0, 4'h0);
        step("R7", 3'd0, 8'h00, 8'h00, 1, 1, 0, 0, 4'h0);
        idle("R12");
        // R11 asynchronous reset mid-cycle
        @(negedge clk);
        compare(pend_tag);
        rst_n = 1'b0;
        #1;
        {m_c, m_ac, m_z, m_ov, m_pdf, m_to} = '0;
        compare("R11");
        @(negedge clk);
        rst_n = 1'b1;
        op_class = '0; halt_evt = 0; clrwdt_evt = 0; wdt_tmo_evt = 0; wr_en = 0;
        pend_tag = "R11";
        // Seeded random mix
        for (int i = 0; i < 600; i++) begin
            logic [2:0] rop;
            int ev;
            rop = 3'($urandom % 8);
            ev  = int'($urandom % 16);
            step("R10", rop, 8'($urandom), 8'($urandom), ev[0] & ev[3],
                 ev[1] & ev[3], ev[2] & (ev < 12), ($urandom % 3) == 0, 4'($urandom));
        end
        idle("R12");
        @(negedge clk);
        compare(pend_tag);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule